// File: doc/BRIEF.md
# Two-Slot Alternating Handshake Stage

This block is one register stage for a valid/ready streaming pipeline. It replaces the single holding register of a plain stage with two storage slots that are filled and emptied in turn. A write pointer picks the slot for the next accepted item. A read pointer picks the slot whose contents are shown downstream. A small occupancy count, from zero to two, drives both handshake outputs.

The upstream ready output is decoded only from that count: it is high whenever a slot is free. The downstream ready input therefore never reaches the upstream side through combinational logic. The backward timing path ends at this stage, while throughput stays at one item per cycle. The data width is a parameter. Reset is synchronous and active low.

Top module: `pingpong_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stage empties. After that edge `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when fewer than two items are held. It does not change when `out_ready` changes within a cycle.
- R3: `out_valid` is 1 exactly when at least one item is held.
- R4: Items leave in the order they were accepted. No item is lost or duplicated under any pattern of `in_valid` and `out_ready`.
- R5: An item is accepted only on a cycle with `in_valid` and `in_ready` both 1. Data offered while the stage is full is not stored and never appears at `out_data`.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` keep their values into the next cycle.
- R7: An accept and a release in the same cycle with one item held leave one item held. That item is the newly accepted one.
- R8: An item accepted into an empty stage is offered at `out_data` in the next cycle. With `in_valid` and `out_ready` held high, one item is released every cycle.
- R9: The stage holds at most two items. After two accepts with no release, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream offers an item |
| in_ready | output | 1 | Stage has a free slot |
| in_data | input | DATA_W | Upstream item |
| out_valid | output | 1 | Stage holds an item |
| out_ready | input | 1 | Downstream takes the item this cycle |
| out_data | output | DATA_W | Oldest held item |

## Verification
The sweep targets three cases. The first is a simultaneous accept and release at one item held: a design that stalls or double-counts there would lose or repeat an item. The second is the full state with new data offered: a design that overwrites a slot would release the intruding value. The third is a pointer that fails to toggle: it would show stale or reordered data.

The bench also toggles `out_ready` in the middle of a cycle and watches `in_ready`, to catch any combinational path between them. A continuous-flow run confirms one release per cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef logic [1:0] occ_t;

  localparam occ_t OCC_EMPTY = 2'd0;
  localparam occ_t OCC_FULL  = 2'd2;

  // occupancy after one cycle of accept/release activity
  function automatic occ_t occ_next(occ_t cur, logic push, logic pop);
    occ_t res;
    case ({push, pop})
      2'b10:   res = cur + 2'd1;
      2'b01:   res = cur - 2'd1;
      default: res = cur;
    endcase
    return res;
  endfunction

  // slot selector advances by toggling on each event
  function automatic logic slot_step(logic sel, logic adv);
    return sel ^ adv;
  endfunction

endpackage

// File: rtl/pp_slot_bank.sv
module pp_slot_bank #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NSLOT = 2;

  logic [DATA_W-1:0] slot_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (wr_en && (wr_sel == 1'(i))) begin
        slot_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_sel];

  // R4
  slot_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_q[$past(wr_sel)] == $past(wr_data));

  // R5
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(slot_q[0]) && $stable(slot_q[1]));

endmodule

// File: rtl/pp_occupancy.sv
module pp_occupancy
  import pp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output occ_t occ,
  output logic wr_sel,
  output logic rd_sel,
  output logic has_free,
  output logic has_item
);

  occ_t occ_q;
  logic wr_q, rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= OCC_EMPTY;
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      occ_q <= occ_next(occ_q, push, pop);
      wr_q  <= slot_step(wr_q, push);
      rd_q  <= slot_step(rd_q, pop);
    end
  end

  assign occ      = occ_q;
  assign wr_sel   = wr_q;
  assign rd_sel   = rd_q;
  assign has_free = (occ_q != OCC_FULL);
  assign has_item = (occ_q != OCC_EMPTY);

  // R9
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_FULL);

  // R4
  ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == 2'd1) |-> (wr_q != rd_q));

  // R7
  swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && occ_q == 2'd1) |=> (occ_q == 2'd1));

  // R8
  wr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (wr_q != $past(wr_q)));

endmodule

// File: rtl/pingpong_stage.sv
module pingpong_stage
  import pp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  occ_t occ;
  logic wr_sel, rd_sel, has_free, has_item;
  logic push_evt, pop_evt;

  assign push_evt = in_valid && has_free;
  assign pop_evt  = has_item && out_ready;

  pp_occupancy u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_evt),
    .pop      (pop_evt),
    .occ      (occ),
    .wr_sel   (wr_sel),
    .rd_sel   (rd_sel),
    .has_free (has_free),
    .has_item (has_item)
  );

  pp_slot_bank #(.DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_evt),
    .wr_sel  (wr_sel),
    .wr_data (in_data),
    .rd_sel  (rd_sel),
    .rd_data (out_data)
  );

  assign in_ready  = has_free;
  assign out_valid = has_item;

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  fill_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid) |=> (out_valid && out_data == $past(in_data)));

  // R3
  full_has_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  // R2
  full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_ready) |=> !in_ready);

  // R1 / R3
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);

  // R5 / R9
  occ_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) <= 1);

endmodule

// File: tb/sim_pingpong_stage.sv
`timescale 1ns/1ps
module sim_pingpong_stage;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, out_valid;
  logic [W-1:0] out_data;

  always #2 clk = ~clk;

  pingpong_stage #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bench model: queue of up to two values
  int           mcnt = 0;
  logic [W-1:0] mq0 = '0, mq1 = '0;
  logic [W-1:0] seq = 8'd1;
  int           pops = 0;
  bit           held_prev = 0;
  logic [W-1:0] held_val = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit iv, bit ordy);
    bit mpush, mpop;
    int ir0;
    @(negedge clk);
    chk(out_valid == (mcnt > 0), "R3 out_valid", out_valid, mcnt > 0);
    chk(in_ready == (mcnt < 2), "R2/R9 in_ready", in_ready, mcnt < 2);
    if (mcnt > 0) chk(out_data == mq0, "R4 order", out_data, mq0);
    if (held_prev) chk(out_valid && out_data == held_val, "R6 hold", out_data, held_val);
    ir0 = in_ready;
    in_valid  = iv;
    in_data   = (iv && mcnt < 2) ? seq : (seq ^ 8'hA5);
    out_ready = ordy;
    #1;
    chk(in_ready == ir0, "R2 no path from out_ready", in_ready, ir0);
    mpush = iv && (mcnt < 2);
    mpop  = ordy && (mcnt > 0);
    held_prev = (mcnt > 0) && !ordy;
    held_val  = mq0;
    @(posedge clk);
    if (mpop) begin
      mq0 = mq1;
      mcnt--;
      pops++;
    end
    if (mpush) begin
      if (mcnt == 0) mq0 = seq; else mq1 = seq;
      mcnt++;
      seq = seq + 8'd1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    @(posedge clk);
    mcnt = 0; held_prev = 0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready, "R1 in_ready after reset", in_ready, 1);
  endtask

  initial begin
    do_reset();

    // R8: empty stage shows an item one cycle after accept
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);

    // R9 / R5: fill, then offer intruders while full
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0);
    @(negedge clk);
    chk(!in_ready, "R9 full after two accepts", in_ready, 0);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1);

    // R7: one held, accept and release together
    step(1'b1, 1'b0);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);

    // R8: continuous flow, one release per cycle
    pops = 0;
    for (int k = 0; k < 32; k++) step(1'b1, 1'b1);
    chk(pops == 31, "R8 throughput", pops, 31);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);

    // R4 / R6: every 4-cycle pattern of in_valid and out_ready
    for (int p = 0; p < 256; p++) begin
      for (int c = 0; c < 4; c++) step(p[2*c], p[2*c+1]);
      for (int c = 0; c < 3; c++) step(1'b0, 1'b1);
    end

    // R1: reset while full
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    do_reset();
    step(1'b0, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule